// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block passes short messages between a host processor and a local processor, in both directions. Each direction has its own message buffer of 128 bytes (32 words) and a 32-bit doorbell word. The sender fills message words through its own register bus. It then writes the doorbell with bit 31 (busy) set, which raises an interrupt on the receiving side. The receiver reads the message and writes the doorbell with busy cleared. Clearing busy raises a completion indication back at the sender.

Both sides have a word-wide register bus with a write strobe, a read strobe, a 6-bit word address and 32-bit data. Read data is registered. The lower half of each side's address space (0x00 to 0x1F) is a message window: a write lands in the outgoing buffer, and a read returns the incoming buffer. The upper half holds the control registers.

The local side has a status register, an interrupt mask and a sticky completion register. The host side has a status register whose bit 8 tells the host that its message was consumed. The field outputs give the length, protocol and command of the message waiting for the local side, so decode logic needs no register read. Protocol 3 is management traffic and protocol 4 is command traffic. A typical first message from the local side is a management "firmware ready" with command 3, length 1 and busy set, which is the word 0x8003_0C01.

Top module: `dbell_mailbox`

## Requirements
- R1: After reset, both doorbells, the local mask, the local completion register, the host status register, both error flags and both interrupt outputs are zero.
- R2: A word written by one side at window address k (0x00 to 0x1F) is returned when the other side reads window address k. Read data appears on the cycle after the read strobe.
- R3: Doorbell word fields are: length in bits 9:0, protocol in bits 13:10, command in bits 19:16, busy in bit 31. A sender write with busy set, while its doorbell is idle, stores the whole word. The host-to-local doorbell is written at host 0x20 and read at local 0x20. The local-to-host doorbell is written at local 0x21 and read at host 0x21. The local field outputs show bits 9:0, 13:10 and 19:16 of the host-to-local doorbell.
- R4: A sender write with busy set while that doorbell is already busy is ignored, and the sender's error flag is set. The host error flag is bit 0 of host 0x23 and the local error flag is bit 0 of local 0x25. Writing 1 to the flag clears it.
- R5: A sender write with busy set and a length above 128 is ignored and sets the sender's error flag. A length of exactly 128 is accepted.
- R6: Bit 0 of local status (local 0x22) equals the host-to-local busy bit. The local mask is at local 0x23. The local interrupt output is registered: one cycle after the state, it equals (that busy bit AND mask bit 0) OR (completion bit AND mask bit 11). It is zero while those mask bits are zero.
- R7: A local write to local 0x20 with bit 31 clear drops host-to-local busy and keeps the other doorbell bits. It also sets host status bit 8 (host 0x22), which is sticky and cleared by the host writing 1 to bit 8.
- R8: A host write to host 0x21 with bit 31 clear, while local-to-host busy is set, drops that busy bit. It also sets bit 0 of local 0x24, which is sticky and cleared by the local side writing 1 to bit 0.
- R9: Host status bit 0 equals local-to-host busy. The host interrupt output is registered: one cycle after the state, it equals (local-to-host busy OR host status bit 8). A local write to local 0x21 with bit 31 clear withdraws the message, drops the host interrupt, and does not set the local completion bit.
- R10: A receiver write to its incoming doorbell with bit 31 set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Host write strobe |
| h_re | input | 1 | Host read strobe |
| h_addr | input | 6 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after h_re |
| h_irq | output | 1 | Host interrupt |
| l_we | input | 1 | Local write strobe |
| l_re | input | 1 | Local read strobe |
| l_addr | input | 6 | Local word address |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, valid the cycle after l_re |
| l_irq | output | 1 | Local interrupt |
| l_in_len | output | 10 | Length field of host-to-local doorbell |
| l_in_proto | output | 4 | Protocol field of host-to-local doorbell |
| l_in_cmd | output | 4 | Command field of host-to-local doorbell |

## Verification
A write takes effect at the clock edge that samples its strobe. Doorbells, status, sticky bits and field outputs therefore show the new value one edge after the write, and both interrupt outputs follow one edge after that. Read data is due one edge after the read strobe. The bench drives inputs on falling edges and samples on falling edges. Before each check it waits one falling edge for register results and two falling edges for interrupt results.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int DB_W      = 32;
  localparam int BUSY_BIT  = 31;
  localparam int LEN_LSB   = 0;
  localparam int LEN_W     = 10;
  localparam int PROTO_LSB = 10;
  localparam int PROTO_W   = 4;
  localparam int CMD_LSB   = 16;
  localparam int CMD_W     = 4;

  // control-half register indices, local side
  localparam int L_DB_IN  = 0;
  localparam int L_DB_OUT = 1;
  localparam int L_STAT   = 2;
  localparam int L_MASK   = 3;
  localparam int L_CLRST  = 4;
  localparam int L_ERR    = 5;
  // control-half register indices, host side
  localparam int H_DB_OUT = 0;
  localparam int H_DB_IN  = 1;
  localparam int H_STAT   = 2;
  localparam int H_ERR    = 3;

  localparam int MASK_IN_BIT  = 0;
  localparam int MASK_CLR_BIT = 11;
  localparam int HDONE_BIT    = 8;

  typedef struct packed {
    logic [CMD_W-1:0]   cmd;
    logic [PROTO_W-1:0] proto;
    logic [LEN_W-1:0]   len;
  } db_fields_t;

  function automatic db_fields_t db_split(input logic [DB_W-1:0] w);
    db_fields_t f;
    f.len   = w[LEN_LSB   +: LEN_W];
    f.proto = w[PROTO_LSB +: PROTO_W];
    f.cmd   = w[CMD_LSB   +: CMD_W];
    return f;
  endfunction
endpackage

// File: rtl/dbell_ram.sv
// Simple dual-port message buffer: one write port, one registered read port.
module dbell_ram #(
  parameter int WORDS = 32,
  parameter int W     = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [IW-1:0] ra,
  output logic [W-1:0]  rq
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/dbell_reg.sv
// One doorbell word with busy handshake between a sender and a receiver.
module dbell_reg
  import dbell_pkg::*;
#(
  parameter int MAX_LEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            snd_we,
  input  logic [DB_W-1:0] snd_wd,
  input  logic            rcv_clr,
  output logic [DB_W-1:0] q,
  output logic            consumed,
  output logic            reject
);
  logic            ring_req;
  logic            len_bad;
  logic [DB_W-1:0] nxt;

  always_comb begin
    ring_req = snd_we & snd_wd[BUSY_BIT];
    len_bad  = snd_wd[LEN_LSB +: LEN_W] > LEN_W'(MAX_LEN);
    reject   = ring_req & (q[BUSY_BIT] | len_bad);
    consumed = rcv_clr & q[BUSY_BIT];
    nxt      = q;
    if (consumed)           nxt[BUSY_BIT] = 1'b0;
    if (snd_we && !reject)  nxt = snd_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
  import dbell_pkg::*;
#(
  parameter int MSG_BYTES = 128,
  localparam int WORDS    = MSG_BYTES / 4,
  localparam int AW       = $clog2(WORDS) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_we,
  input  logic               h_re,
  input  logic [AW-1:0]      h_addr,
  input  logic [DB_W-1:0]    h_wdata,
  output logic [DB_W-1:0]    h_rdata,
  output logic               h_irq,
  input  logic               l_we,
  input  logic               l_re,
  input  logic [AW-1:0]      l_addr,
  input  logic [DB_W-1:0]    l_wdata,
  output logic [DB_W-1:0]    l_rdata,
  output logic               l_irq,
  output logic [LEN_W-1:0]   l_in_len,
  output logic [PROTO_W-1:0] l_in_proto,
  output logic [CMD_W-1:0]   l_in_cmd
);
  localparam int IW = AW - 1;

  // address decode
  logic          h_win, l_win;
  logic [IW-1:0] h_idx, l_idx;
  assign h_win = ~h_addr[AW-1];
  assign l_win = ~l_addr[AW-1];
  assign h_idx = h_addr[IW-1:0];
  assign l_idx = l_addr[IW-1:0];

  function automatic logic hit(input logic we, input logic win,
                               input logic [IW-1:0] idx, input int r);
    return we & ~win & (idx == IW'(r));
  endfunction

  // doorbells
  logic [DB_W-1:0] h2l_q, l2h_q;
  logic            h2l_done_ev, h2l_rej, l2h_done_ev, l2h_rej;

  dbell_reg #(.MAX_LEN(MSG_BYTES)) u_db_h2l (
    .clk(clk), .rst(rst),
    .snd_we(hit(h_we, h_win, h_idx, H_DB_OUT)), .snd_wd(h_wdata),
    .rcv_clr(hit(l_we, l_win, l_idx, L_DB_IN) & ~l_wdata[BUSY_BIT]),
    .q(h2l_q), .consumed(h2l_done_ev), .reject(h2l_rej)
  );

  dbell_reg #(.MAX_LEN(MSG_BYTES)) u_db_l2h (
    .clk(clk), .rst(rst),
    .snd_we(hit(l_we, l_win, l_idx, L_DB_OUT)), .snd_wd(l_wdata),
    .rcv_clr(hit(h_we, h_win, h_idx, H_DB_IN) & ~h_wdata[BUSY_BIT]),
    .q(l2h_q), .consumed(l2h_done_ev), .reject(l2h_rej)
  );

  // message buffers, one per direction
  logic [DB_W-1:0] h2l_ram_q, l2h_ram_q;

  dbell_ram #(.WORDS(WORDS), .W(DB_W)) u_ram_h2l (
    .clk(clk), .we(h_we & h_win), .wa(h_idx), .wd(h_wdata),
    .re(l_re & l_win), .ra(l_idx), .rq(h2l_ram_q)
  );

  dbell_ram #(.WORDS(WORDS), .W(DB_W)) u_ram_l2h (
    .clk(clk), .we(l_we & l_win), .wa(l_idx), .wd(l_wdata),
    .re(h_re & h_win), .ra(h_idx), .rq(l2h_ram_q)
  );

  // local control state
  logic [DB_W-1:0] mask_q;
  logic            clr_sts_q, l_err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      clr_sts_q <= 1'b0;
      l_err_q   <= 1'b0;
    end else begin
      if (hit(l_we, l_win, l_idx, L_MASK)) mask_q <= l_wdata;
      if (l2h_done_ev)                                     clr_sts_q <= 1'b1;
      else if (hit(l_we, l_win, l_idx, L_CLRST) && l_wdata[0]) clr_sts_q <= 1'b0;
      if (l2h_rej)                                         l_err_q <= 1'b1;
      else if (hit(l_we, l_win, l_idx, L_ERR) && l_wdata[0])   l_err_q <= 1'b0;
    end
  end

  // host control state
  logic h_done_q, h_err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_done_q <= 1'b0;
      h_err_q  <= 1'b0;
    end else begin
      if (h2l_done_ev)                                          h_done_q <= 1'b1;
      else if (hit(h_we, h_win, h_idx, H_STAT) && h_wdata[HDONE_BIT]) h_done_q <= 1'b0;
      if (h2l_rej)                                              h_err_q <= 1'b1;
      else if (hit(h_we, h_win, h_idx, H_ERR) && h_wdata[0])        h_err_q <= 1'b0;
    end
  end

  // interrupts, registered
  logic l_irq_q, h_irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_irq_q <= 1'b0;
      h_irq_q <= 1'b0;
    end else begin
      l_irq_q <= (h2l_q[BUSY_BIT] & mask_q[MASK_IN_BIT])
               | (clr_sts_q & mask_q[MASK_CLR_BIT]);
      h_irq_q <= l2h_q[BUSY_BIT] | h_done_q;
    end
  end

  assign l_irq = l_irq_q;
  assign h_irq = h_irq_q;

  // register read paths
  logic [DB_W-1:0] l_reg_q, h_reg_q;
  logic            l_sel_ram_q, h_sel_ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_reg_q     <= '0;
      l_sel_ram_q <= 1'b0;
    end else if (l_re) begin
      l_sel_ram_q <= l_win;
      case (int'(l_idx))
        L_DB_IN:  l_reg_q <= h2l_q;
        L_DB_OUT: l_reg_q <= l2h_q;
        L_STAT:   l_reg_q <= {{(DB_W-1){1'b0}}, h2l_q[BUSY_BIT]};
        L_MASK:   l_reg_q <= mask_q;
        L_CLRST:  l_reg_q <= {{(DB_W-1){1'b0}}, clr_sts_q};
        L_ERR:    l_reg_q <= {{(DB_W-1){1'b0}}, l_err_q};
        default:  l_reg_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_reg_q     <= '0;
      h_sel_ram_q <= 1'b0;
    end else if (h_re) begin
      h_sel_ram_q <= h_win;
      case (int'(h_idx))
        H_DB_OUT: h_reg_q <= h2l_q;
        H_DB_IN:  h_reg_q <= l2h_q;
        H_STAT: begin
          h_reg_q            <= '0;
          h_reg_q[0]         <= l2h_q[BUSY_BIT];
          h_reg_q[HDONE_BIT] <= h_done_q;
        end
        H_ERR:    h_reg_q <= {{(DB_W-1){1'b0}}, h_err_q};
        default:  h_reg_q <= '0;
      endcase
    end
  end

  assign l_rdata = l_sel_ram_q ? h2l_ram_q : l_reg_q;
  assign h_rdata = h_sel_ram_q ? l2h_ram_q : h_reg_q;

  // field extraction of the waiting inbound message
  db_fields_t in_f;
  assign in_f       = db_split(h2l_q);
  assign l_in_len   = in_f.len;
  assign l_in_proto = in_f.proto;
  assign l_in_cmd   = in_f.cmd;
endmodule

// File: rtl/dbell_mailbox_chk.sv
module dbell_mailbox_chk #(
  parameter int MSG_BYTES = 128
) (
  input logic        clk,
  input logic        rst,
  input logic        h_we,
  input logic        l_we,
  input logic        h_irq,
  input logic        l_irq,
  input logic [31:0] h2l_q,
  input logic [31:0] l2h_q,
  input logic [31:0] mask_q,
  input logic        clr_sts_q,
  input logic        h_done_q
);
  // R6: with both enable bits clear the local interrupt stays low
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!mask_q[0] && !mask_q[11]) |-> !l_irq);

  // R9: a pending outbound message keeps the host interrupt up next cycle
  p_host_irq_r9: assert property (@(posedge clk) disable iff (rst)
    $past(l2h_q[31]) |-> h_irq);

  // R7: inbound busy only falls after some bus write
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(h2l_q[31]) |-> $past(l_we || h_we));

  // R7: consumed flag only rises when a message was pending
  p_done_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(h_done_q) |-> $past(h2l_q[31]));

  // R8: completion bit only rises when an outbound message was pending
  p_clr_src_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(clr_sts_q) |-> $past(l2h_q[31]));

  // R5: a busy doorbell never carries an oversize length
  p_len_h2l_r5: assert property (@(posedge clk) disable iff (rst)
    h2l_q[31] |-> (int'(h2l_q[9:0]) <= MSG_BYTES));
  p_len_l2h_r5: assert property (@(posedge clk) disable iff (rst)
    l2h_q[31] |-> (int'(l2h_q[9:0]) <= MSG_BYTES));
endmodule

bind dbell_mailbox dbell_mailbox_chk #(.MSG_BYTES(MSG_BYTES)) u_chk (
  .clk(clk), .rst(rst), .h_we(h_we), .l_we(l_we),
  .h_irq(h_irq), .l_irq(l_irq), .h2l_q(h2l_q), .l2h_q(l2h_q),
  .mask_q(mask_q), .clr_sts_q(clr_sts_q), .h_done_q(h_done_q)
);

// File: tb/dbell_mailbox_bench.sv
module dbell_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_we = 0, h_re = 0, l_we = 0, l_re = 0;
  logic [5:0]  h_addr = '0, l_addr = '0;
  logic [31:0] h_wdata = '0, l_wdata = '0;
  logic [31:0] h_rdata, l_rdata;
  logic        h_irq, l_irq;
  logic [9:0]  l_in_len;
  logic [3:0]  l_in_proto, l_in_cmd;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [5:0] LA_DBIN = 6'h20, LA_DBOUT = 6'h21, LA_STAT = 6'h22,
                         LA_MASK = 6'h23, LA_CLR = 6'h24, LA_ERR = 6'h25;
  localparam logic [5:0] HA_DBOUT = 6'h20, HA_DBIN = 6'h21, HA_STAT = 6'h22,
                         HA_ERR = 6'h23;

  always #5 clk = ~clk;

  dbell_mailbox u_dbell_mailbox (
    .clk(clk), .rst(rst),
    .h_we(h_we), .h_re(h_re), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .l_we(l_we), .l_re(l_re), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq(l_irq),
    .l_in_len(l_in_len), .l_in_proto(l_in_proto), .l_in_cmd(l_in_cmd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic hw(input logic [5:0] a, input logic [31:0] d);
    h_we = 1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_we = 0;
  endtask

  task automatic lw(input logic [5:0] a, input logic [31:0] d);
    l_we = 1; l_addr = a; l_wdata = d;
    @(negedge clk);
    l_we = 0;
  endtask

  task automatic hr(input logic [5:0] a, output logic [31:0] d);
    h_re = 1; h_addr = a;
    @(negedge clk);
    h_re = 0; d = h_rdata;
  endtask

  task automatic lr(input logic [5:0] a, output logic [31:0] d);
    l_re = 1; l_addr = a;
    @(negedge clk);
    l_re = 0; d = l_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 l_irq", {31'b0, l_irq}, 0);
    check("R1 h_irq", {31'b0, h_irq}, 0);
    lr(LA_MASK, d);  check("R1 mask", d, 0);
    lr(LA_DBIN, d);  check("R1 inbound doorbell", d, 0);
    lr(LA_CLR, d);   check("R1 completion", d, 0);
    lr(LA_ERR, d);   check("R1 local err", d, 0);
    hr(HA_STAT, d);  check("R1 host status", d, 0);
    hr(HA_DBIN, d);  check("R1 outbound doorbell", d, 0);
    hr(HA_ERR, d);   check("R1 host err", d, 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    hw(6'h00, 32'hA5A5_0001);
    hw(6'h05, 32'h1234_5678);
    hw(6'h1F, 32'hDEAD_BEEF);
    lw(6'h03, 32'h0BAD_F00D);
    lr(6'h00, d); check("R2 h2l word0", d, 32'hA5A5_0001);
    lr(6'h05, d); check("R2 h2l word5", d, 32'h1234_5678);
    lr(6'h1F, d); check("R2 h2l word31", d, 32'hDEAD_BEEF);
    hr(6'h03, d); check("R2 l2h word3", d, 32'h0BAD_F00D);
  endtask

  task automatic t_ring();
    logic [31:0] d;
    hw(HA_DBOUT, 32'h8005_1040);  // cmd 5, proto 4, len 64
    lr(LA_DBIN, d); check("R3 inbound doorbell", d, 32'h8005_1040);
    check("R3 len", {22'b0, l_in_len}, 64);
    check("R3 proto", {28'b0, l_in_proto}, 4);
    check("R3 cmd", {28'b0, l_in_cmd}, 5);
    lr(LA_STAT, d); check("R6 status busy", d, 1);
    settle();
    check("R6 masked irq", {31'b0, l_irq}, 0);
    lw(LA_MASK, 32'h0000_0001);
    settle();
    check("R6 irq enabled", {31'b0, l_irq}, 1);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    hw(HA_DBOUT, 32'h8000_1008);
    lr(LA_DBIN, d); check("R4 ring while busy ignored", d, 32'h8005_1040);
    hr(HA_ERR, d);  check("R4 host err set", d, 1);
    hw(HA_ERR, 32'h1);
    hr(HA_ERR, d);  check("R4 host err cleared", d, 0);
  endtask

  task automatic t_rcv_ignore();
    logic [31:0] d;
    hw(HA_DBIN, 32'h8000_0004);
    lr(LA_DBOUT, d); check("R10 receiver set ignored", d, 0);
    settle();
    check("R10 no host irq", {31'b0, h_irq}, 0);
    lw(LA_DBIN, 32'h8000_0000);
    lr(LA_DBIN, d); check("R10 local set ignored", d, 32'h8005_1040);
  endtask

  task automatic t_consume();
    logic [31:0] d;
    lw(LA_DBIN, 32'h0);
    lr(LA_DBIN, d); check("R7 busy cleared, rest kept", d, 32'h0005_1040);
    settle();
    check("R6 l_irq drops", {31'b0, l_irq}, 0);
    hr(HA_STAT, d); check("R7 host status bit8", d, 32'h100);
    check("R9 h_irq on consume", {31'b0, h_irq}, 1);
    hw(HA_STAT, 32'h100);
    hr(HA_STAT, d); check("R7 bit8 cleared", d, 0);
    settle();
    check("R9 h_irq drops", {31'b0, h_irq}, 0);
  endtask

  task automatic t_len();
    logic [31:0] d;
    hw(HA_DBOUT, 32'h8000_0081);  // len 129
    lr(LA_DBIN, d); check("R5 oversize ignored", d, 32'h0005_1040);
    hr(HA_ERR, d);  check("R5 err set", d, 1);
    hw(HA_ERR, 32'h1);
    hw(HA_DBOUT, 32'h8000_0080);  // len 128
    lr(LA_DBIN, d); check("R5 len 128 accepted", d, 32'h8000_0080);
    hr(HA_ERR, d);  check("R5 no err at 128", d, 0);
    lw(LA_DBIN, 32'h0);
    hw(HA_STAT, 32'h100);
  endtask

  task automatic t_fw_ready();
    logic [31:0] d;
    lw(LA_DBOUT, 32'h8003_0C01);  // management, cmd 3, len 1
    hr(HA_DBIN, d); check("R3 outbound doorbell", d, 32'h8003_0C01);
    hr(HA_STAT, d); check("R9 host status busy", d, 1);
    check("R9 h_irq pending", {31'b0, h_irq}, 1);
    lw(LA_DBOUT, 32'h8000_0002);
    lr(LA_ERR, d);  check("R4 local err set", d, 1);
    lw(LA_ERR, 32'h1);
    lr(LA_ERR, d);  check("R4 local err cleared", d, 0);
  endtask

  task automatic t_host_clear();
    logic [31:0] d;
    lw(LA_MASK, 32'h0000_0800);
    hw(HA_DBIN, 32'h0);
    lr(LA_CLR, d); check("R8 completion set", d, 1);
    hr(HA_DBIN, d); check("R8 busy dropped", d, 32'h0003_0C01);
    settle();
    check("R8 l_irq via bit 11", {31'b0, l_irq}, 1);
    check("R9 h_irq after clear", {31'b0, h_irq}, 0);
    lw(LA_CLR, 32'h1);
    lr(LA_CLR, d); check("R8 completion cleared", d, 0);
    settle();
    check("R8 l_irq drops", {31'b0, l_irq}, 0);
  endtask

  task automatic t_retract();
    logic [31:0] d;
    lw(LA_DBOUT, 32'h8003_0C01);
    settle();
    check("R9 h_irq raised", {31'b0, h_irq}, 1);
    lw(LA_DBOUT, 32'h0);
    settle();
    check("R9 h_irq withdrawn", {31'b0, h_irq}, 0);
    lr(LA_CLR, d); check("R9 no completion on withdraw", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_window();
    t_ring();
    t_overrun();
    t_rcv_ignore();
    t_consume();
    t_len();
    t_fw_ready();
    t_host_clear();
    t_retract();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule